// File: doc/BRIEF.md
# Host Aperture Window Translator

This block sits between a host-facing register aperture and an internal backplane. Every host access carries a byte offset into the aperture and a read or write strobe. The block decodes the offset against one of several layouts, chosen by a layout code. It then forwards the access, one cycle later, to one of four targets: the backplane, a serial-PROM store, the host-bridge core's registers, or the common core's registers. The forwarded access carries an address that has already been translated.

Some regions of the aperture are fixed and map to a local target at a region-relative offset. Other regions are sliding 4 KB windows. The backplane page of a sliding window comes from one of two programmable base registers. These base registers are written and read back through a separate configuration port. Offsets that fall outside the active layout are not forwarded: reads of them return all-ones and writes to them are dropped.

Top module: `bar_xlate`

## Requirements
- R1: Both window base registers reset to zero. A configuration write with `cfg_sel` = 0 loads window 0 and one with `cfg_sel` = 1 loads window 1. `cfg_rdata` returns the register picked by `cfg_sel` bit for bit as written, including bits 11:0.
- R2: A configuration write to one window register leaves the other window register's value, and the mapping that depends on it, unchanged.
- R3: In every layout, offsets 0x0000–0x0FFF go to the backplane target. The translated address is window 0's bits 31:12 followed by offset bits 11:0.
- R4: Layout code 0 (8 KB aperture) maps three fixed regions. Offsets 0x1000–0x17FF go to the PROM at address offset−0x1000. Offsets 0x1800–0x1BFF go to the host core at address offset−0x1800. Offsets 0x1C00–0x1FFF go to the host core at address 0xC00+(offset−0x1C00).
- R5: Layout code 1 (16 KB aperture) maps three fixed 4 KB regions. The region at 0x1000 goes to the PROM, the region at 0x2000 to the host core and the region at 0x3000 to the common core. In each region the address is offset bits 11:0.
- R6: Layout codes 2 and 3 (16 KB aperture) behave identically. Offsets 0x1000–0x1FFF go to the backplane through window 1, with the address formed from window 1's bits 31:12 and offset bits 11:0. The region at 0x2000 goes to the host core and the region at 0x3000 goes to the common core, each at offset bits 11:0. These layouts have no PROM region.
- R7: Under layout code 0, an access at an offset of 0x2000 or above is not forwarded, so `acc_vld` stays low. A read there returns 0xFFFFFFFF on `host_rdata` in the following cycle.
- R8: `acc_vld`, `acc_we`, `acc_re`, `acc_sel`, `acc_addr` and `acc_wdata` describe the access strobed in the previous cycle. A cycle with no strobe gives `acc_vld` = 0. When both strobes are set, the access is a write. `acc_wdata` carries the host write data unchanged.
- R9: The `acc_sel` encoding is 0 for the backplane, 1 for the PROM, 2 for the host core and 3 for the common core.
- R10: For a read that hits a region, `host_rdata` passes `tgt_rdata` through in the cycle after the strobe.
- R11: An access strobed in the same cycle as a configuration write is translated with the window value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_sel | input | 2 | Aperture layout code |
| host_ofs | input | OFS_W | Host byte offset into the aperture |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data returned to the host |
| cfg_we | input | 1 | Window register write enable |
| cfg_sel | input | 1 | Window register select (0 or 1) |
| cfg_wdata | input | AW | Window register write data |
| cfg_rdata | output | AW | Readback of the selected window register |
| tgt_rdata | input | DW | Read data from the addressed target |
| acc_vld | output | 1 | Forwarded access valid |
| acc_we | output | 1 | Forwarded access is a write |
| acc_re | output | 1 | Forwarded access is a read |
| acc_sel | output | 2 | Target select |
| acc_addr | output | AW | Translated target address |
| acc_wdata | output | DW | Forwarded write data |

## Verification
The bench builds the block with its default widths: a 14-bit offset and 32-bit addresses and data. At that size, the complete 16 K offset range can be read under each of the four layout codes. This covers every region boundary, including the 2 KB and 1 KB splits of the 8 KB layout and the region above its aperture. Window values are reloaded between layouts with non-zero low bits, which exposes any leak of base bits 11:0 into the translated address. A coarser write sweep and directed cases cover write precedence and a window write in the same cycle as an access.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;

  // Target select encoding, seen on acc_sel
  typedef enum logic [1:0] {
    TGT_BPLANE = 2'd0,
    TGT_PROM   = 2'd1,
    TGT_HOST   = 2'd2,
    TGT_COMMON = 2'd3
  } tgt_e;

  // Layout codes
  localparam logic [1:0] LAY_SMALL = 2'd0;  // 8 KB, split fixed region
  localparam logic [1:0] LAY_PROM  = 2'd1;  // 16 KB, one sliding window
  // codes 2 and 3: 16 KB, two sliding windows

  localparam int PAGE_BITS = 12;            // 4 KB region size
  localparam int APT_BITS  = 14;            // 16 KB largest aperture

  typedef struct packed {
    logic                 hit;
    tgt_e                 sel;
    logic                 use_win1;
    logic [PAGE_BITS-1:0] lofs;
  } dec_t;

endpackage

// File: rtl/bar_rst_sync.sv
module bar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/bar_win_regs.sv
module bar_win_regs #(
  parameter int AW    = 32,
  parameter int NWIN  = 2,
  parameter int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [AW-1:0]             cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]   win_q,
  output logic [AW-1:0]             cfg_rdata
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic          en;
    logic [AW-1:0] base_d;
    logic [AW-1:0] base_q;

    assign en = cfg_we && (cfg_sel == SEL_W'(g));

    always_comb begin
      base_d = base_q;
      if (en) base_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_d;
    end

    assign win_q[g] = base_q;
  end

  assign cfg_rdata = win_q[cfg_sel];

endmodule

// File: rtl/bar_decode.sv
module bar_decode
  import bar_xlate_pkg::*;
#(
  parameter int OFS_W = 14   // must be at least APT_BITS
) (
  input  logic [1:0]       layout_sel,
  input  logic [OFS_W-1:0] host_ofs,
  output dec_t             dec
);

  logic                 above;
  logic [1:0]           region;
  logic [PAGE_BITS-1:0] lo;

  if (OFS_W > APT_BITS) begin : g_wide
    assign above = |host_ofs[OFS_W-1:APT_BITS];
  end else begin : g_exact
    assign above = 1'b0;
  end

  assign region = host_ofs[APT_BITS-1:PAGE_BITS];
  assign lo     = host_ofs[PAGE_BITS-1:0];

  always_comb begin
    dec.hit      = 1'b0;
    dec.sel      = TGT_BPLANE;
    dec.use_win1 = 1'b0;
    dec.lofs     = lo;
    if (!above) begin
      case (region)
        2'd0: dec.hit = 1'b1;
        2'd1: begin
          dec.hit = 1'b1;
          case (layout_sel)
            LAY_SMALL: begin
              if (!lo[11]) begin
                dec.sel  = TGT_PROM;
                dec.lofs = {1'b0, lo[10:0]};
              end else begin
                // lower 1 KB -> core 0x000, upper 1 KB -> core 0xC00
                dec.sel  = TGT_HOST;
                dec.lofs = {lo[10], lo[10], lo[9:0]};
              end
            end
            LAY_PROM: dec.sel = TGT_PROM;
            default:  dec.use_win1 = 1'b1;
          endcase
        end
        2'd2: begin
          dec.hit = (layout_sel != LAY_SMALL);
          dec.sel = TGT_HOST;
        end
        default: begin
          dec.hit = (layout_sel != LAY_SMALL);
          dec.sel = TGT_COMMON;
        end
      endcase
    end
  end

endmodule

// File: rtl/bar_acc_stage.sv
module bar_acc_stage
  import bar_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  dec_t          dec,
  input  logic [AW-1:0] win0,
  input  logic [AW-1:0] win1,
  input  logic [DW-1:0] host_wdata,
  output logic          acc_vld,
  output logic          acc_we,
  output logic          acc_re,
  output logic [1:0]    acc_sel,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          rd_miss
);

  localparam int HI_W = AW - PAGE_BITS;

  logic          strobe;
  logic          vld_d, we_d, re_d, miss_d;
  logic [AW-1:0] base;
  logic [AW-1:0] addr_d;

  assign strobe = host_rd | host_wr;

  always_comb begin
    vld_d  = strobe & dec.hit;
    we_d   = host_wr & dec.hit;
    re_d   = host_rd & ~host_wr & dec.hit;
    miss_d = host_rd & ~host_wr & ~dec.hit;
    base   = dec.use_win1 ? win1 : win0;
    if (dec.sel == TGT_BPLANE) addr_d = {base[AW-1:PAGE_BITS], dec.lofs};
    else                       addr_d = {{HI_W{1'b0}}, dec.lofs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld <= 1'b0;
      acc_we  <= 1'b0;
      acc_re  <= 1'b0;
      rd_miss <= 1'b0;
    end else begin
      acc_vld <= vld_d;
      acc_we  <= we_d;
      acc_re  <= re_d;
      rd_miss <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sel   <= 2'd0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else if (strobe) begin
      acc_sel   <= dec.sel;
      acc_addr  <= addr_d;
      acc_wdata <= host_wdata;
    end
  end

endmodule

// File: rtl/bar_xlate.sv
module bar_xlate
  import bar_xlate_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       layout_sel,
  input  logic [OFS_W-1:0] host_ofs,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic [DW-1:0]    tgt_rdata,
  output logic             acc_vld,
  output logic             acc_we,
  output logic             acc_re,
  output logic [1:0]       acc_sel,
  output logic [AW-1:0]    acc_addr,
  output logic [DW-1:0]    acc_wdata
);

  localparam int NWIN = 2;

  logic                  rst_s_n;
  logic [NWIN-1:0][AW-1:0] win_q;
  logic [AW-1:0]         win0_w;
  logic [AW-1:0]         win1_w;
  dec_t                  dec;
  logic                  rd_miss;

  bar_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  bar_win_regs #(.AW(AW), .NWIN(NWIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .win_q     (win_q),
    .cfg_rdata (cfg_rdata)
  );

  assign win0_w = win_q[0];
  assign win1_w = win_q[1];

  bar_decode #(.OFS_W(OFS_W)) u_dec (
    .layout_sel (layout_sel),
    .host_ofs   (host_ofs),
    .dec        (dec)
  );

  bar_acc_stage #(.AW(AW), .DW(DW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .dec        (dec),
    .win0       (win0_w),
    .win1       (win1_w),
    .host_wdata (host_wdata),
    .acc_vld    (acc_vld),
    .acc_we     (acc_we),
    .acc_re     (acc_re),
    .acc_sel    (acc_sel),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .rd_miss    (rd_miss)
  );

  assign host_rdata = rd_miss ? {DW{1'b1}} : tgt_rdata;

endmodule

// File: rtl/bar_xlate_chk.sv
module bar_xlate_chk #(
  parameter int OFS_W = 14,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic [1:0]       layout_sel,
  input logic [OFS_W-1:0] host_ofs,
  input logic             host_rd,
  input logic             host_wr,
  input logic [DW-1:0]    host_rdata,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [AW-1:0]    cfg_wdata,
  input logic             acc_vld,
  input logic             acc_we,
  input logic             acc_re,
  input logic [1:0]       acc_sel,
  input logic [AW-1:0]    acc_addr,
  input logic [AW-1:0]    win0,
  input logic [AW-1:0]    win1
);

  assert_win0_load_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && !cfg_sel) |=> (win0 == $past(cfg_wdata)));

  assert_win1_load_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && cfg_sel) |=> (win1 == $past(cfg_wdata)));

  assert_win1_kept_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && !cfg_sel) |=> (win1 == $past(win1)));

  assert_win0_kept_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && cfg_sel) |=> (win0 == $past(win0)));

  // R3 and R11: low page goes through window 0 as held before any same-cycle write
  assert_low_page_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((host_rd || host_wr) && (host_ofs[OFS_W-1:12] == '0)) |=>
      (acc_vld && acc_sel == 2'd0 &&
       acc_addr[11:0] == $past(host_ofs[11:0]) &&
       acc_addr[AW-1:12] == $past(win0[AW-1:12])));

  assert_oob_read_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_rd && !host_wr && layout_sel == 2'd0 && host_ofs[13]) |=>
      (!acc_vld && host_rdata == {DW{1'b1}}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(host_rd || host_wr) |=> (!acc_vld && !acc_we && !acc_re));

  assert_dir_excl_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(acc_we && acc_re));

endmodule

bind bar_xlate bar_xlate_chk #(.OFS_W(OFS_W), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .layout_sel (layout_sel),
  .host_ofs   (host_ofs),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .acc_vld    (acc_vld),
  .acc_we     (acc_we),
  .acc_re     (acc_re),
  .acc_sel    (acc_sel),
  .acc_addr   (acc_addr),
  .win0       (win0_w),
  .win1       (win1_w)
);

// File: tb/bar_xlate_tb.sv
module bar_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  layout_sel;
  logic [13:0] host_ofs;
  logic        host_rd, host_wr;
  logic [31:0] host_wdata, host_rdata;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [31:0] tgt_rdata;
  logic        acc_vld, acc_we, acc_re;
  logic [1:0]  acc_sel;
  logic [31:0] acc_addr, acc_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] w0m = '0;
  logic [31:0] w1m = '0;

  always #10 clk = ~clk;  // 50 MHz

  bar_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .host_ofs(host_ofs),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tgt_rdata(tgt_rdata),
    .acc_vld(acc_vld), .acc_we(acc_we), .acc_re(acc_re), .acc_sel(acc_sel),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Reference map, from the requirement text
  function automatic void model(input int lay, input int o, input logic [31:0] w0,
                                input logic [31:0] w1, output bit hit, output int sel,
                                output logic [31:0] addr);
    int region = o / 4096;
    int lo = o % 4096;
    hit = 1; sel = 0; addr = 0;
    if (region == 0) begin
      sel = 0; addr = (w0 & 32'hFFFF_F000) + lo;
    end else if (lay == 0) begin
      if (o < 'h1800)      begin sel = 1; addr = o - 'h1000; end
      else if (o < 'h1C00) begin sel = 2; addr = o - 'h1800; end
      else if (o < 'h2000) begin sel = 2; addr = 'hC00 + (o - 'h1C00); end
      else hit = 0;
    end else if (lay == 1) begin
      sel = region; addr = lo;
    end else begin
      if (region == 1) begin sel = 0; addr = (w1 & 32'hFFFF_F000) + lo; end
      else begin sel = region; addr = lo; end
    end
  endfunction

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) w1m = d; else w0m = d;
  endtask

  task automatic access(input int lay, input int o, input bit rd, input bit wr,
                        input logic [31:0] wd);
    bit hit; int sel; logic [31:0] addr; string tag;
    layout_sel = lay[1:0]; host_ofs = o[13:0];
    host_rd = rd; host_wr = wr; host_wdata = wd;
    tgt_rdata = 32'hC0DE_0000 ^ o;
    model(lay, o, w0m, w1m, hit, sel, addr);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    if (!hit)           tag = "R7";
    else if (o < 4096)  tag = "R3/R9";
    else if (lay == 0)  tag = "R4/R9";
    else if (lay == 1)  tag = "R5/R9";
    else                tag = "R6/R9";
    if (hit) begin
      chk({tag, " access"}, {27'd0, acc_vld, acc_we, acc_re, acc_sel, acc_addr},
          {27'd0, 1'b1, wr, rd & ~wr, sel[1:0], addr});
      if (wr) chk("R8 wdata", acc_wdata, wd);
      else    chk("R10 rdata", host_rdata, tgt_rdata);
    end else begin
      chk("R7 not forwarded", acc_vld, 0);
      if (rd && !wr) chk("R7 ones", host_rdata, 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; layout_sel = 0; host_ofs = 0; host_rd = 0; host_wr = 0;
    host_wdata = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; tgt_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset vld", acc_vld, 0);
    cfg_sel = 0; #1 chk("R1 reset win0", cfg_rdata, 0);
    cfg_sel = 1; #1 chk("R1 reset win1", cfg_rdata, 0);

    // R1 readback, R2 independence
    cfg_write(0, 32'h1234_5ABC);
    cfg_write(1, 32'hFEDC_B321);
    cfg_sel = 0; #1 chk("R1 readback win0", cfg_rdata, 32'h1234_5ABC);
    cfg_sel = 1; #1 chk("R1 readback win1", cfg_rdata, 32'hFEDC_B321);
    cfg_write(0, 32'h0BAD_F00D);
    cfg_sel = 1; #1 chk("R2 win1 kept", cfg_rdata, 32'hFEDC_B321);
    access(2, 'h1444, 1, 0, 0);  // R2 mapping via win1 unchanged
    cfg_write(1, 32'h7777_7FFF);
    cfg_sel = 0; #1 chk("R2 win0 kept", cfg_rdata, 32'h0BAD_F00D);
    access(3, 'h0010, 1, 0, 0);

    // Full read sweep per layout code
    for (int lay = 0; lay < 4; lay++) begin
      cfg_write(0, 32'hA5A5_0000 + lay * 32'h0011_1FFF);
      cfg_write(1, 32'h5A00_0ABC + lay * 32'h0101_0101);
      for (int o = 0; o < 16384; o++) access(lay, o, 1, 0, 0);
    end

    // Write sweep
    for (int lay = 0; lay < 4; lay++)
      for (int o = 0; o < 16384; o += 64) access(lay, o, 0, 1, 32'h3C3C_0000 + o);

    // R8 both strobes: write wins
    access(1, 'h2010, 1, 1, 32'hDEAD_BEEF);
    access(0, 'h3000, 1, 1, 32'h0);
    // R8 idle cycle
    @(negedge clk);
    chk("R8 idle vld", acc_vld, 0);

    // R11 same-cycle window write uses old base
    begin
      logic [31:0] old0;
      old0 = w0m;
      layout_sel = 2; host_ofs = 14'h0123; host_rd = 1;
      cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h9999_9000;
      @(negedge clk);
      host_rd = 0; cfg_we = 0; w0m = 32'h9999_9000;
      chk("R11 old base", acc_addr, (old0 & 32'hFFFF_F000) | 32'h123);
      access(2, 'h0123, 1, 0, 0);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule